// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display: active-high horizontal and vertical sync, a blanking flag, a display-enable flag and the current pixel column and row. Software programs the mode through a small synchronous register port. Each axis has three 32-bit timing registers. Each register holds a pair of thresholds, and each threshold is stored as its value minus one. The lower threshold sits in bits 15:0 and the upper threshold in bits 31:16.

An axis is laid out in this order: active region, front porch, sync pulse, back porch. Blanking starts where the active region ends and lasts until the line or frame total. A single enable bit starts and stops the counters. The enable bit and all timing registers are protected by a lock. Software must write a fixed code to the lock register before these registers accept writes, and writing zero closes the lock again. The normal sequence is: unlock, clear enable, write the six timing registers, set enable, lock.

The register port and the counters share one pixel clock. A small controller has two states. In `ST_HALT` the counters are held at zero and all timing outputs are idle. In `ST_RUN` the counters advance. The transition `ST_HALT`→`ST_RUN` is taken on the edge after the enable bit is seen set. The transition `ST_RUN`→`ST_HALT` is taken on the edge after the enable bit is seen clear, and the counters are cleared on that same edge.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the lock is closed, the enable bit and every timing register read as zero, and the outputs are idle: hsync=0, vsync=0, de=0, blank=1, px_x=0, px_y=0.
- R2: While running, px_x increases by one on each clock. After px_x equals the horizontal total-minus-one field (address 2, bits 31:16), it returns to 0.
- R3: px_y advances by one only on the clock where px_x wraps. After px_y equals the vertical total-minus-one field (address 5, bits 31:16), it returns to 0.
- R4: de is high exactly when px_x ≤ the horizontal active-minus-one field (address 2, bits 15:0) and px_y ≤ the vertical active-minus-one field (address 5, bits 15:0). A line therefore carries exactly the programmed number of active pixels.
- R5: blank is high when px_x lies above the blank-start-minus-one field (address 3, bits 15:0) and at or below the blank-end-minus-one field (address 3, bits 31:16). It is also high when px_y satisfies the same test against address 6.
- R6: hsync is high exactly when px_x lies above the sync-start-minus-one field and at or below the sync-end-minus-one field (address 4, low and high halves). vsync follows the same rule for px_y against address 7. Both are low whenever the generator is halted.
- R7: The enable bit is address 1, bit 0. After the write that sets it, the outputs stay idle for one more clock and then present pixel (0,0) with valid timing. One clock after the enable bit is cleared, the outputs are idle again and both counters are zero.
- R8: Writing 0x0000_4758 to address 0 opens the lock, writing 0 closes it, and any other value leaves the lock unchanged. Reading address 0 returns the lock state in bit 0 (1 = open).
- R9: While the lock is closed, writes to addresses 1 to 7 have no effect, both on the stored values and on the outputs.
- R10: Reads are combinational on reg_raddr. Addresses 2 to 7 return the stored 32-bit value, and address 1 returns the enable bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, also clocks the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking interval flag |
| de | output | 1 | Display enable (visible pixel) |
| px_x | output | 16 | Current column |
| px_y | output | 16 | Current row |

## Verification
The hardest situations to reach from the ports are the exact cycle on which the generator starts, and the proof that a write blocked by the lock has no effect. The stimulus starts the generator with a write and samples on the two following clocks, so the one-clock idle gap is observed directly. Every clock of two complete frames is then compared, in two different modes, against column and row values computed from the cycle index. A blocked enable write is followed by several clocks in which the outputs must stay idle, and blocked timing writes are read back to confirm the stored values did not change.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int FW   = 16;   // width of one timing field
    localparam int DW   = 32;   // register width
    localparam int AW   = 3;    // register address width
    localparam int NTIM = 6;    // timing registers (three per axis)
    localparam int CFG_EN_BIT = 0;

    localparam logic [AW-1:0] A_LOCK = 3'd0;
    localparam logic [AW-1:0] A_CFG  = 3'd1;
    localparam logic [AW-1:0] A_H_AT = 3'd2;
    localparam logic [AW-1:0] A_H_BL = 3'd3;
    localparam logic [AW-1:0] A_H_SY = 3'd4;
    localparam logic [AW-1:0] A_V_AT = 3'd5;
    localparam logic [AW-1:0] A_V_BL = 3'd6;
    localparam logic [AW-1:0] A_V_SY = 3'd7;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tgen_state_e;

    // thresholds of one axis, each stored as value minus one
    typedef struct packed {
        logic [FW-1:0] act_m1;
        logic [FW-1:0] tot_m1;
        logic [FW-1:0] bs_m1;
        logic [FW-1:0] be_m1;
        logic [FW-1:0] ss_m1;
        logic [FW-1:0] se_m1;
    } axis_cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter logic [DW-1:0] UNLOCK_CODE = 32'h0000_4758
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          unlocked,
    output logic          tgen_en,
    output axis_cfg_t     hcfg,
    output axis_cfg_t     vcfg
);
    logic          unlocked_q;
    logic          en_q;
    logic [DW-1:0] tim_q [NTIM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
            en_q       <= 1'b0;
            for (int i = 0; i < NTIM; i++) tim_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_LOCK) begin
                if (wr_data == UNLOCK_CODE)
                    unlocked_q <= 1'b1;
                else if (wr_data == '0)
                    unlocked_q <= 1'b0;
            end else if (unlocked_q) begin
                if (wr_addr == A_CFG)
                    en_q <= wr_data[CFG_EN_BIT];
                else
                    tim_q[3'(wr_addr - A_H_AT)] <= wr_data;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_LOCK:  rd_data = {{(DW-1){1'b0}}, unlocked_q};
            A_CFG:   rd_data = {{(DW-1){1'b0}}, en_q};
            default: rd_data = tim_q[3'(rd_addr - A_H_AT)];
        endcase
    end

    assign unlocked = unlocked_q;
    assign tgen_en  = en_q;

    assign hcfg.act_m1 = tim_q[0][FW-1:0];
    assign hcfg.tot_m1 = tim_q[0][DW-1:FW];
    assign hcfg.bs_m1  = tim_q[1][FW-1:0];
    assign hcfg.be_m1  = tim_q[1][DW-1:FW];
    assign hcfg.ss_m1  = tim_q[2][FW-1:0];
    assign hcfg.se_m1  = tim_q[2][DW-1:FW];
    assign vcfg.act_m1 = tim_q[3][FW-1:0];
    assign vcfg.tot_m1 = tim_q[3][DW-1:FW];
    assign vcfg.bs_m1  = tim_q[4][FW-1:0];
    assign vcfg.be_m1  = tim_q[4][DW-1:FW];
    assign vcfg.ss_m1  = tim_q[5][FW-1:0];
    assign vcfg.se_m1  = tim_q[5][DW-1:FW];
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  axis_cfg_t     cfg,
    output logic [FW-1:0] cnt,
    output logic          wrap,
    output logic          in_act,
    output logic          in_blank,
    output logic          in_sync
);
    logic [FW-1:0] cnt_q;

    assign wrap = step && (cnt_q == cfg.tot_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    assign cnt      = cnt_q;
    assign in_act   = (cnt_q <= cfg.act_m1);
    assign in_blank = (cnt_q > cfg.bs_m1) && (cnt_q <= cfg.be_m1);
    assign in_sync  = (cnt_q > cfg.ss_m1) && (cnt_q <= cfg.se_m1);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter logic [31:0] UNLOCK_CODE = 32'h0000_4758
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        hsync,
    output logic        vsync,
    output logic        blank,
    output logic        de,
    output logic [15:0] px_x,
    output logic [15:0] px_y
);
    tgen_state_e   state_q, state_d;
    axis_cfg_t     hcfg, vcfg;
    logic          unlocked, tgen_en;
    logic          running, counting, clr;
    logic [FW-1:0] h_cnt, v_cnt;
    logic          h_wrap, v_wrap;
    logic          h_act, h_blank, h_sync;
    logic          v_act, v_blank, v_sync;

    dtg_regs #(.UNLOCK_CODE(UNLOCK_CODE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .unlocked(unlocked), .tgen_en(tgen_en),
        .hcfg(hcfg), .vcfg(vcfg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: HALT->RUN on enable, RUN->HALT on disable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (tgen_en)  state_d = ST_RUN;
            ST_RUN:  if (!tgen_en) state_d = ST_HALT;
        endcase
    end

    assign running  = (state_q == ST_RUN);
    assign counting = running && tgen_en;
    assign clr      = !counting;

    dtg_axis u_hor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(counting), .cfg(hcfg),
        .cnt(h_cnt), .wrap(h_wrap),
        .in_act(h_act), .in_blank(h_blank), .in_sync(h_sync)
    );

    dtg_axis u_ver (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(h_wrap), .cfg(vcfg),
        .cnt(v_cnt), .wrap(v_wrap),
        .in_act(v_act), .in_blank(v_blank), .in_sync(v_sync)
    );

    // outputs per state
    always_comb begin
        hsync = 1'b0;
        vsync = 1'b0;
        de    = 1'b0;
        blank = 1'b1;
        px_x  = '0;
        px_y  = '0;
        unique case (state_q)
            ST_HALT: ;
            ST_RUN: begin
                hsync = h_sync;
                vsync = v_sync;
                de    = h_act && v_act;
                blank = h_blank || v_blank;
                px_x  = h_cnt;
                px_y  = v_cnt;
            end
        endcase
    end

    logic unused_v_wrap;
    assign unused_v_wrap = v_wrap;
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
    import dtg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          running,
    input logic          tgen_en,
    input logic          unlocked,
    input logic          reg_wr,
    input logic [AW-1:0] reg_waddr,
    input axis_cfg_t     hcfg,
    input axis_cfg_t     vcfg,
    input logic [FW-1:0] px_x,
    input logic [FW-1:0] px_y,
    input logic          hsync,
    input logic          vsync,
    input logic          de
);
    a_r2_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tgen_en && px_x != hcfg.tot_m1) |=> (px_x == $past(px_x) + 16'd1));

    a_r2_x_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tgen_en && px_x == hcfg.tot_m1) |=> (px_x == '0));

    a_r3_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tgen_en && px_x != hcfg.tot_m1) |=> $stable(px_y));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!hsync && !vsync && !de));

    a_r7_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !tgen_en |=> (px_x == '0 && px_y == '0 && !hsync && !vsync && !de));

    a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && reg_wr && reg_waddr != A_LOCK) |=>
            ($stable(hcfg) && $stable(vcfg) && $stable(tgen_en)));
endmodule

bind disp_timing_gen dtg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .tgen_en(tgen_en),
    .unlocked(unlocked), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .hcfg(hcfg), .vcfg(vcfg), .px_x(px_x), .px_y(px_y),
    .hsync(hsync), .vsync(vsync), .de(de)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        hsync, vsync, blank, de;
    logic [15:0] px_x, px_y;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    disp_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
        .px_x(px_x), .px_y(px_y)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] pk(input int lo, input int hi);
        return {16'(hi - 1), 16'(lo - 1)};
    endfunction

    // program and sweep one mode: active, front porch, sync, back porch per axis
    task automatic run_mode(input int ha, input int hf, input int hs, input int hb,
                            input int va, input int vf, input int vs, input int vb);
        int ht = ha + hf + hs + hb;
        int vt = va + vf + vs + vb;
        int line_de = 0;
        int hs_first = -1;
        int vs_first_y = -1;
        logic [31:0] d;
        wr(3'd1, 32'd0);
        wr(3'd2, pk(ha, ht));
        wr(3'd3, pk(ha, ht));
        wr(3'd4, pk(ha + hf, ha + hf + hs));
        wr(3'd5, pk(va, vt));
        wr(3'd6, pk(va, vt));
        wr(3'd7, pk(va + vf, va + vf + vs));
        rd(3'd4, d);
        check(d == pk(ha + hf, ha + hf + hs), "R10 sync reg readback", d, pk(ha + hf, ha + hf + hs));
        wr(3'd1, 32'd1);
        check(!de && blank && px_x == 0, "R7 idle one clock after enable", {de, blank}, 2'b01);
        @(negedge clk);
        for (int n = 0; n < 2 * ht * vt; n++) begin
            int x = n % ht;
            int y = (n / ht) % vt;
            logic e_hs = (x >= ha + hf) && (x < ha + hf + hs);
            logic e_vs = (y >= va + vf) && (y < va + vf + vs);
            logic e_de = (x < ha) && (y < va);
            logic e_bl = (x >= ha) || (y >= va);
            logic [35:0] exp_v = {e_hs, e_vs, e_de, e_bl, 16'(x), 16'(y)};
            logic [35:0] act_v = {hsync, vsync, de, blank, px_x, px_y};
            // R2 R3 R4 R5 R6: full per-clock comparison
            check(act_v == exp_v, "R2 R3 R4 R5 R6 sweep", act_v, exp_v);
            if (n < ht && de) line_de++;
            if (n < ht && hsync && hs_first < 0) hs_first = x;
            if (n < ht * vt && vsync && vs_first_y < 0) vs_first_y = y;
            @(negedge clk);
        end
        check(line_de == ha, "R4 active pixels per line", line_de, ha);
        check(hs_first == ha + hf, "R6 hsync leading edge column", hs_first, ha + hf);
        check(vs_first_y == va + vf, "R6 vsync leading edge row", vs_first_y, va + vf);
        wr(3'd1, 32'd0);
        @(negedge clk);
        check(px_x == 0 && px_y == 0 && !hsync && !vsync && !de && blank,
              "R7 idle after disable", {px_x, px_y, hsync, vsync, de, blank}, 36'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({hsync, vsync, de, blank, px_x, px_y} == 36'h1_0000_0000, "R1 outputs idle",
              {hsync, vsync, de, blank, px_x, px_y}, 36'h1_0000_0000);
        rd(3'd0, d); check(d == 0, "R1 lock closed", d, 0);
        rd(3'd1, d); check(d == 0, "R1 enable clear", d, 0);
        rd(3'd2, d); check(d == 0, "R1 timing reg zero", d, 0);
        // R9: writes blocked while locked
        wr(3'd2, 32'h1234_5678);
        rd(3'd2, d); check(d == 0, "R9 locked timing write ignored", d, 0);
        wr(3'd1, 32'd1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!de && !hsync && blank && px_x == 0, "R9 locked enable ignored",
                  {de, hsync, blank}, 3'b001);
        end
        // R8: wrong code leaves lock closed, right code opens
        wr(3'd0, 32'h0000_1234);
        rd(3'd0, d); check(d == 0, "R8 wrong code", d, 0);
        wr(3'd0, 32'h0000_4758);
        rd(3'd0, d); check(d == 1, "R8 unlock code", d, 1);
        wr(3'd2, 32'h00AB_00CD);
        rd(3'd2, d); check(d == 32'h00AB_00CD, "R10 unlocked write readback", d, 32'h00AB_00CD);
        run_mode(8, 2, 3, 2, 4, 1, 2, 1);
        run_mode(5, 1, 2, 3, 3, 2, 1, 2);
        rd(3'd1, d); check(d == 0, "R10 enable readback", d, 0);
        // R8: zero closes the lock; R9 then blocks changes
        wr(3'd0, 32'd0);
        rd(3'd0, d); check(d == 0, "R8 lock with zero", d, 0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); check(d == pk(5, 11), "R9 locked blank write ignored", d, pk(5, 11));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule